// File: doc/BRIEF.md
# TDM Slot Demultiplexer

This block sits behind a time-slot router and serves one serial controller. The octets routed to that controller arrive one at a time with a frame-start marker. The block counts them from the marker, so it knows which routed slot each octet fills. It then looks up which of up to 64 logical channels owns that slot and hands the octet on, tagged with the channel number. Each channel owns its slots through a 64-bit mask. Bit n of the mask means the n-th routed slot after frame start, not the n-th slot of the physical line. Different channels can share the first few slots by taking alternate bits.

The transmit direction works the same way in reverse. On each outgoing slot tick the block finds the owning channel and asks the upstream source for that channel's next octet. It places the octet in the slot one cycle later. A slot with no owner is filled with all ones.

A channel is either transparent, which is the default, or packet mode. In transparent mode a per-channel flag can mirror each octet so that its most significant bit travels first. In packet mode the octet passes through untouched and is flagged for an external framing engine.

Top module: `tdm_slot_demux`

## Requirements
- R1: After reset, `rx_out_valid` and `tx_out_valid` are low until the first octet or tick that arrives after reset.
- R2: A cycle with the frame-start flag set makes that octet slot 0. Every later octet or tick in the same direction takes the next slot number. Cycles without an octet or tick do not advance the count. A new frame-start flag resets the count at any point.
- R3: A received octet whose slot is claimed by channel c appears exactly one cycle later with `rx_out_valid` high and `rx_out_ch` = c. Output octets come out in the same order as the input octets.
- R4: When several channel masks claim the same slot, the channel with the lowest number takes it, in both directions.
- R5: A received octet in a slot that no channel claims produces no output. Octets beyond slot NUM_SLOTS-1 of a frame also produce no output.
- R6: When a channel has its `cfg_reverse` bit set and its `cfg_hdlc` bit clear, bit i of each octet is moved to bit 7-i. This applies on receive and on transmit.
- R7: When a channel has its `cfg_hdlc` bit set, its octets pass unmodified whatever its reverse bit says, and the matching `*_out_hdlc` output is 1. Transparent octets carry `*_out_hdlc` = 0.
- R8: In the same cycle as a transmit tick for a claimed slot, `tx_fetch_en` is high and `tx_fetch_ch` names the owner. One cycle after every tick, `tx_out_valid` is high and `tx_out_data` holds the fetched octet, shaped as in R6 and R7.
- R9: A transmit tick for an unclaimed slot, or for a slot at or beyond NUM_SLOTS, leaves `tx_fetch_en` low. It yields `tx_out_data` = 8'hFF with `tx_out_hdlc` = 0 one cycle later.
- R10: Two channels with masks 64'hAA and 64'h55 split the first eight routed slots. The 64'h55 channel gets slots 0, 2, 4 and 6. The 64'hAA channel gets slots 1, 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_mask | input | NUM_CH*NUM_SLOTS | Receive slot masks; bits [c*NUM_SLOTS +: NUM_SLOTS] belong to channel c |
| cfg_tx_mask | input | NUM_CH*NUM_SLOTS | Transmit slot masks, same layout |
| cfg_reverse | input | NUM_CH | Per-channel bit-mirror flag (transparent mode only) |
| cfg_hdlc | input | NUM_CH | Per-channel mode: 1 packet mode, 0 transparent |
| rx_valid | input | 1 | An incoming octet is present |
| rx_sof | input | 1 | This incoming octet is routed slot 0 |
| rx_data | input | 8 | Incoming octet |
| rx_out_valid | output | 1 | Demultiplexed octet present |
| rx_out_ch | output | CH_W | Owning channel of the output octet |
| rx_out_data | output | 8 | Output octet |
| rx_out_hdlc | output | 1 | Output octet belongs to a packet-mode channel |
| tx_tick | input | 1 | One outgoing slot is due |
| tx_sof | input | 1 | This outgoing slot is routed slot 0 |
| tx_fetch_en | output | 1 | Octet request for the owning channel |
| tx_fetch_ch | output | CH_W | Channel whose octet is requested |
| tx_fetch_data | input | 8 | Requested octet, returned in the same cycle |
| tx_out_valid | output | 1 | Outgoing slot octet present |
| tx_out_data | output | 8 | Outgoing slot octet |
| tx_out_hdlc | output | 1 | Outgoing octet belongs to a packet-mode channel |

## Verification
A slot counter that drifts shows up within one octet: the next octet comes out with the wrong channel number, or appears when it should be dropped. The scoreboard catches this on the very next cycle. A wrong priority in the owner search, or a reversal applied in the wrong mode, shows up on the first octet of an overlapping or flagged slot. The stimulus places such slots in every frame. A transmit path that loses its place shows up either as a mistimed request at the fetch port or as a fill value where a fetched octet was due.

// File: rtl/tdm_demux_pkg.sv
`timescale 1ns/1ps
package tdm_demux_pkg;

    localparam int OCTET_W = 8;

    typedef logic [OCTET_W-1:0] octet_t;

    // value driven into a transmit slot nobody owns
    localparam octet_t IDLE_FILL = 8'hFF;

    // one registered output lane
    typedef struct packed {
        logic   valid;
        logic   hdlc;
        octet_t data;
    } lane_t;

    function automatic octet_t flip_octet(input octet_t d);
        octet_t r;
        for (int i = 0; i < OCTET_W; i++) begin
            r[i] = d[OCTET_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/tdm_slot_counter.sv
`timescale 1ns/1ps
module tdm_slot_counter #(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sof,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              in_range
);
    logic [SLOT_W:0] next_slot;
    logic [SLOT_W:0] cur_slot;

    // a frame start forces the current octet to slot 0
    assign cur_slot = sof ? '0 : next_slot;
    assign in_range = (cur_slot < (SLOT_W+1)'(NUM_SLOTS));
    assign slot_idx = cur_slot[SLOT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            next_slot <= '0;
        end else if (tick && in_range) begin
            next_slot <= cur_slot + (SLOT_W+1)'(1);
        end
    end
endmodule

// File: rtl/tdm_owner_lookup.sv
`timescale 1ns/1ps
module tdm_owner_lookup #(
    parameter int NUM_CH    = 64,
    parameter int NUM_SLOTS = 64,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_CH*NUM_SLOTS-1:0] mask_flat,
    input  logic [SLOT_W-1:0]           slot_idx,
    input  logic                        probe,
    output logic                        hit,
    output logic [CH_W-1:0]             owner
);
    logic [NUM_CH-1:0] claim;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_claim
        logic [NUM_SLOTS-1:0] row;
        assign row      = mask_flat[c*NUM_SLOTS +: NUM_SLOTS];
        assign claim[c] = probe && row[slot_idx];
    end

    // scan downward so the lowest-numbered claimant is kept
    always_comb begin
        hit   = 1'b0;
        owner = '0;
        for (int c = NUM_CH-1; c >= 0; c--) begin
            if (claim[c]) begin
                hit   = 1'b1;
                owner = CH_W'(c);
            end
        end
    end
endmodule

// File: rtl/tdm_octet_shaper.sv
`timescale 1ns/1ps
module tdm_octet_shaper
    import tdm_demux_pkg::*;
(
    input  octet_t din,
    input  logic   mirror,
    input  logic   packet_mode,
    output octet_t dout
);
    // mirroring is a transparent-mode feature only
    assign dout = (mirror && !packet_mode) ? flip_octet(din) : din;
endmodule

// File: rtl/tdm_slot_demux.sv
`timescale 1ns/1ps
module tdm_slot_demux
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH    = 64,
    parameter int NUM_SLOTS = 64,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CH*NUM_SLOTS-1:0] cfg_rx_mask,
    input  logic [NUM_CH*NUM_SLOTS-1:0] cfg_tx_mask,
    input  logic [NUM_CH-1:0]           cfg_reverse,
    input  logic [NUM_CH-1:0]           cfg_hdlc,
    input  logic                        rx_valid,
    input  logic                        rx_sof,
    input  logic [7:0]                  rx_data,
    output logic                        rx_out_valid,
    output logic [CH_W-1:0]             rx_out_ch,
    output logic [7:0]                  rx_out_data,
    output logic                        rx_out_hdlc,
    input  logic                        tx_tick,
    input  logic                        tx_sof,
    output logic                        tx_fetch_en,
    output logic [CH_W-1:0]             tx_fetch_ch,
    input  logic [7:0]                  tx_fetch_data,
    output logic                        tx_out_valid,
    output logic [7:0]                  tx_out_data,
    output logic                        tx_out_hdlc
);
    // ---------------- receive direction ----------------
    logic [SLOT_W-1:0] rx_slot;
    logic              rx_in_range;
    logic              rx_hit;
    logic [CH_W-1:0]   rx_owner;
    octet_t            rx_shaped;
    lane_t             rx_lane;
    logic [CH_W-1:0]   rx_ch_q;

    tdm_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_rx_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (rx_valid),
        .sof      (rx_sof),
        .slot_idx (rx_slot),
        .in_range (rx_in_range)
    );

    tdm_owner_lookup #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_rx_owner (
        .mask_flat (cfg_rx_mask),
        .slot_idx  (rx_slot),
        .probe     (rx_valid && rx_in_range),
        .hit       (rx_hit),
        .owner     (rx_owner)
    );

    tdm_octet_shaper u_rx_shape (
        .din         (rx_data),
        .mirror      (cfg_reverse[rx_owner]),
        .packet_mode (cfg_hdlc[rx_owner]),
        .dout        (rx_shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_lane <= '0;
            rx_ch_q <= '0;
        end else begin
            rx_lane.valid <= rx_hit;
            if (rx_hit) begin
                rx_lane.hdlc <= cfg_hdlc[rx_owner];
                rx_lane.data <= rx_shaped;
                rx_ch_q      <= rx_owner;
            end
        end
    end

    assign rx_out_valid = rx_lane.valid;
    assign rx_out_hdlc  = rx_lane.hdlc;
    assign rx_out_data  = rx_lane.data;
    assign rx_out_ch    = rx_ch_q;

    // ---------------- transmit direction ----------------
    logic [SLOT_W-1:0] tx_slot;
    logic              tx_in_range;
    logic              tx_hit;
    logic [CH_W-1:0]   tx_owner;
    octet_t            tx_shaped;
    lane_t             tx_lane;

    tdm_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_tx_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tx_tick),
        .sof      (tx_sof),
        .slot_idx (tx_slot),
        .in_range (tx_in_range)
    );

    tdm_owner_lookup #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_tx_owner (
        .mask_flat (cfg_tx_mask),
        .slot_idx  (tx_slot),
        .probe     (tx_tick && tx_in_range),
        .hit       (tx_hit),
        .owner     (tx_owner)
    );

    assign tx_fetch_en = tx_hit;
    assign tx_fetch_ch = tx_owner;

    tdm_octet_shaper u_tx_shape (
        .din         (tx_fetch_data),
        .mirror      (cfg_reverse[tx_owner]),
        .packet_mode (cfg_hdlc[tx_owner]),
        .dout        (tx_shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_lane <= '0;
        end else begin
            tx_lane.valid <= tx_tick;
            if (tx_tick) begin
                tx_lane.hdlc <= tx_hit && cfg_hdlc[tx_owner];
                tx_lane.data <= tx_hit ? tx_shaped : IDLE_FILL;
            end
        end
    end

    assign tx_out_valid = tx_lane.valid;
    assign tx_out_hdlc  = tx_lane.hdlc;
    assign tx_out_data  = tx_lane.data;
endmodule

// File: rtl/tdm_slot_demux_chk.sv
`timescale 1ns/1ps
module tdm_slot_demux_chk #(
    parameter int NUM_CH = 64,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            rx_valid,
    input logic [7:0]      rx_data,
    input logic            rx_out_valid,
    input logic [7:0]      rx_out_data,
    input logic            rx_out_hdlc,
    input logic            tx_tick,
    input logic            tx_fetch_en,
    input logic [CH_W-1:0] tx_fetch_ch,
    input logic            tx_out_valid,
    input logic [7:0]      tx_out_data,
    input logic            tx_out_hdlc
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_out_valid && !tx_out_valid));

    assert_rx_needs_input_R3: assert property (@(posedge clk) disable iff (rst)
        rx_out_valid |-> $past(rx_valid));

    assert_rx_idle_silent_R5: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !rx_out_valid);

    assert_packet_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_out_valid && rx_out_hdlc) |-> (rx_out_data == $past(rx_data)));

    assert_tx_slot_cadence_R8: assert property (@(posedge clk) disable iff (rst)
        tx_tick |=> tx_out_valid);

    assert_tx_fetch_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        tx_fetch_en |-> tx_tick);

    assert_tx_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_tick && !tx_fetch_en) |=> (tx_out_data == 8'hFF && !tx_out_hdlc));

    assert_tx_fetch_ch_known_R8: assert property (@(posedge clk) disable iff (rst)
        tx_fetch_en |-> !$isunknown(tx_fetch_ch));
endmodule

bind tdm_slot_demux tdm_slot_demux_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_out_valid (rx_out_valid),
    .rx_out_data  (rx_out_data),
    .rx_out_hdlc  (rx_out_hdlc),
    .tx_tick      (tx_tick),
    .tx_fetch_en  (tx_fetch_en),
    .tx_fetch_ch  (tx_fetch_ch),
    .tx_out_valid (tx_out_valid),
    .tx_out_data  (tx_out_data),
    .tx_out_hdlc  (tx_out_hdlc)
);

// File: tb/tb_tdm_slot_demux.sv
`timescale 1ns/1ps
module tb_tdm_slot_demux;
    localparam int NC = 64;
    localparam int NS = 64;
    localparam int CW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic rst;
    logic [NS-1:0] rxm [NC];
    logic [NS-1:0] txm [NC];
    logic [NC-1:0] rev, hdl;
    logic [NC*NS-1:0] rx_flat, tx_flat;
    logic [7:0] seed;

    logic          rx_valid, rx_sof;
    logic [7:0]    rx_data;
    logic          rx_out_valid, rx_out_hdlc;
    logic [CW-1:0] rx_out_ch;
    logic [7:0]    rx_out_data;
    logic          tx_tick, tx_sof, tx_fetch_en;
    logic [CW-1:0] tx_fetch_ch;
    logic [7:0]    tx_fetch_data;
    logic          tx_out_valid, tx_out_hdlc;
    logic [7:0]    tx_out_data;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            rx_flat[c*NS +: NS] = rxm[c];
            tx_flat[c*NS +: NS] = txm[c];
        end
    end

    function automatic logic [7:0] fetch_pattern(input logic [CW-1:0] ch);
        return {2'b01, ch} ^ seed;
    endfunction

    // upstream source answers a fetch in the same cycle
    always_comb tx_fetch_data = fetch_pattern(tx_fetch_ch);

    tdm_slot_demux #(.NUM_CH(NC), .NUM_SLOTS(NS)) dut (
        .clk(clk), .rst(rst),
        .cfg_rx_mask(rx_flat), .cfg_tx_mask(tx_flat),
        .cfg_reverse(rev), .cfg_hdlc(hdl),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .rx_out_valid(rx_out_valid), .rx_out_ch(rx_out_ch),
        .rx_out_data(rx_out_data), .rx_out_hdlc(rx_out_hdlc),
        .tx_tick(tx_tick), .tx_sof(tx_sof),
        .tx_fetch_en(tx_fetch_en), .tx_fetch_ch(tx_fetch_ch),
        .tx_fetch_data(tx_fetch_data),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .tx_out_hdlc(tx_out_hdlc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int rx_cnt = 0;
    int tx_cnt = 0;

    logic [14:0] rxq [$];   // {hdlc, ch, data}
    string       rxtag [$];
    logic [8:0]  txq [$];   // {hdlc, data}
    string       txtag [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int find_owner(input bit is_tx, input int slot);
        for (int c = 0; c < NC; c++) begin
            if (is_tx ? txm[c][slot] : rxm[c][slot]) return c;
        end
        return -1;
    endfunction

    function automatic int claim_count(input bit is_tx, input int slot);
        int n = 0;
        for (int c = 0; c < NC; c++) begin
            if (is_tx ? txm[c][slot] : rxm[c][slot]) n++;
        end
        return n;
    endfunction

    function automatic logic [7:0] mirror8(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    function automatic logic [7:0] shape(input logic [7:0] d, input int c);
        return (rev[c] && !hdl[c]) ? mirror8(d) : d;
    endfunction

    function automatic string pick_tag(input bit is_tx, input int slot, input int o,
                                       input string dflt);
        if (hdl[o]) return "R7";
        if (rev[o]) return "R6";
        if (claim_count(is_tx, slot) > 1) return "R4";
        return dflt;
    endfunction

    task automatic idle();
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; tx_tick = 1'b0; tx_sof = 1'b0;
    endtask

    task automatic rx_octet(input bit sof, input logic [7:0] d, input string tag);
        int idx;
        int o;
        @(posedge clk); #1;
        tx_tick = 1'b0; tx_sof = 1'b0;
        rx_valid = 1'b1; rx_sof = sof; rx_data = d;
        idx = sof ? 0 : rx_cnt;
        if (idx < NS) begin
            rx_cnt = idx + 1;
            o = find_owner(1'b0, idx);
            if (o >= 0) begin
                rxq.push_back({hdl[o], CW'(o), shape(d, o)});
                rxtag.push_back(pick_tag(1'b0, idx, o, tag));
            end
        end
    endtask

    task automatic tx_slot(input bit sof, input string tag);
        int idx;
        int o;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0;
        tx_tick = 1'b1; tx_sof = sof;
        idx = sof ? 0 : tx_cnt;
        o = -1;
        if (idx < NS) begin
            tx_cnt = idx + 1;
            o = find_owner(1'b1, idx);
        end
        #0.5;
        if (o >= 0) begin
            check(tx_fetch_en === 1'b1, "R8", "fetch enable", 32'(tx_fetch_en), 32'd1);
            check(tx_fetch_ch === CW'(o), "R8", "fetch channel", 32'(tx_fetch_ch), 32'(o));
            txq.push_back({hdl[o], shape(fetch_pattern(CW'(o)), o)});
            txtag.push_back(pick_tag(1'b1, idx, o, tag));
        end else begin
            check(tx_fetch_en === 1'b0, "R9", "fetch enable", 32'(tx_fetch_en), 32'd0);
            txq.push_back({1'b0, 8'hFF});
            txtag.push_back("R9");
        end
    endtask

    task automatic drain(input string tag);
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rxq.size() == 0, tag, "rx items left", 32'(rxq.size()), 32'd0);
        check(txq.size() == 0, tag, "tx items left", 32'(txq.size()), 32'd0);
    endtask

    // monitor: compare outputs against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rx_out_valid) begin
                if (rxq.size() == 0) begin
                    check(1'b0, "R5", "unexpected rx output", {17'd0, rx_out_hdlc, rx_out_ch, rx_out_data}, 32'd0);
                end else begin
                    logic [14:0] e;
                    string t;
                    e = rxq.pop_front();
                    t = rxtag.pop_front();
                    check({rx_out_hdlc, rx_out_ch, rx_out_data} === e, t, "rx {hdlc,ch,data}",
                          {17'd0, rx_out_hdlc, rx_out_ch, rx_out_data}, {17'd0, e});
                end
            end
            if (tx_out_valid) begin
                if (txq.size() == 0) begin
                    check(1'b0, "R8", "unexpected tx output", {23'd0, tx_out_hdlc, tx_out_data}, 32'd0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = txq.pop_front();
                    t = txtag.pop_front();
                    check({tx_out_hdlc, tx_out_data} === e, t, "tx {hdlc,data}",
                          {23'd0, tx_out_hdlc, tx_out_data}, {23'd0, e});
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        rx_valid = 0; rx_sof = 0; rx_data = 0; tx_tick = 0; tx_sof = 0;
        seed = 8'h5A;
        rev = '0; hdl = '0;
        for (int c = 0; c < NC; c++) begin rxm[c] = '0; txm[c] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rx_out_valid === 1'b0, "R1", "rx valid in reset", 32'(rx_out_valid), 32'd0);
        check(tx_out_valid === 1'b0, "R1", "tx valid in reset", 32'(tx_out_valid), 32'd0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(rx_out_valid === 1'b0, "R1", "rx valid after reset", 32'(rx_out_valid), 32'd0);
        check(tx_out_valid === 1'b0, "R1", "tx valid after reset", 32'(tx_out_valid), 32'd0);

        // receive configuration
        rxm[5]  = 64'h08;                 // overlaps ch16 on slot 3
        rxm[16] = 64'hAA;  rev[16] = 1'b1;
        rxm[17] = 64'h55;  rev[17] = 1'b1;
        rxm[19] = 64'hFF00; rev[19] = 1'b1; hdl[19] = 1'b1;
        rxm[40] = 64'h0003_0000;          // plain transparent channel
        rxm[63] = 64'h8000_0000_0000_0000;

        // frame 1: interleaved split, with gaps that must not advance the count
        rx_octet(1'b1, 8'h11, "R10");
        for (int i = 1; i < 20; i++) begin
            rx_octet(1'b0, 8'(i*37 + 3), (i < 8) ? "R10" : "R3");
            if (i == 4 || i == 11) idle();
        end
        drain("R10");

        // frame 2: runs past the last slot; late octets dropped
        rx_octet(1'b1, 8'hC3, "R5");
        for (int i = 1; i < 70; i++) rx_octet(1'b0, 8'(i*11 + 1), "R5");
        drain("R5");

        // frame 3: frame start arrives mid-frame and restarts the count
        rx_octet(1'b1, 8'h01, "R2");
        for (int i = 1; i < 5; i++) rx_octet(1'b0, 8'(8'h20 + i), "R2");
        rx_octet(1'b1, 8'h81, "R2");
        for (int i = 1; i < 4; i++) rx_octet(1'b0, 8'(8'h40 + i), "R2");
        drain("R2");

        // transmit configuration
        txm[2]  = 64'hF0;  rev[2] = 1'b1;
        txm[9]  = 64'h3C;                 // loses slots 4,5 to ch2
        txm[30] = 64'h1;   rev[30] = 1'b1; hdl[30] = 1'b1;
        txm[45] = 64'h0000_0100_0000_0000;
        txm[63] = 64'h8000_0000_0000_0000;
        seed = 8'hA7;
        tx_slot(1'b1, "R8");
        for (int i = 1; i < 70; i++) tx_slot(1'b0, "R8");
        drain("R8");

        // transmit restart mid-frame with a new source pattern
        seed = 8'h3C;
        tx_slot(1'b1, "R2");
        for (int i = 1; i < 6; i++) tx_slot(1'b0, "R2");
        tx_slot(1'b1, "R2");
        for (int i = 1; i < 9; i++) tx_slot(1'b0, "R2");
        drain("R2");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule